// File: doc/BRIEF.md
# Auxiliary Frame-Word Masked Insertion

This block sits beside the framer of a serial radio link. It overlays words supplied by user logic onto the outgoing frame stream, one bit at a time under a mask. A free-running set of nested position counters announces which frame word is current. The position has three parts: the hyperframe number, the basic-frame index inside the hyperframe, and the 32-bit word index inside the basic frame. User logic answers each announced position with a data word and a mask word. They must arrive a fixed number of cycles later, which is 1 + `AUX_LATENCY`. For every mask bit that is set, the outgoing bit comes from the user data and not from the framer.

Alongside the position, a 4-bit lane indicator shows which bytes of the announced word carry control-word content. Each 32-bit word is sent on the link starting with its most significant byte. The comma character opens every hyperframe, at hyperframe 0, basic frame 0, word 0, in the first byte. That byte must never be overwritten. If user logic masks any bit of it, the framer's byte still goes out, and an error pulse flags the misuse. A sticky bit keeps a record of any error until user logic clears it.

Top module: `aux_frame_merge`

## Requirements
- R1: The position counters advance once per cycle after reset. The word index changes fastest and wraps at `WORDS_PER_BF`. The basic-frame index advances when the word index wraps, and itself wraps at `BF_COUNT`. The hyperframe number advances when both inner counters wrap, and wraps at `HF_COUNT`.
- R2: `ctrlSlot` is registered and changes on the same edge as the position outputs. At word index 0 it holds the lanes of the first `CW_BYTES` bytes. Bit 3 stands for bits [31:24], the first byte sent, and bit 0 stands for bits [7:0]. At every other word index it is 0.
- R3: The data and mask applied in cycle c+1+`AUX_LATENCY` belong to the position shown in cycle c. `txWord` presents their merged result one cycle after they are applied.
- R4: Each output bit equals the data bit where its mask bit is 1 and the framer bit where its mask bit is 0. This holds at every position except the comma byte.
- R5: The byte lanes are ordered so that bits [31:24] are the first byte sent and bits [7:0] the last. The comma occupies bits [31:24] of the word at hyperframe 0, basic frame 0, word 0.
- R6: At the comma position, `txWord[31:24]` always equals the framer's byte, whatever the mask holds. The other three bytes of that word merge normally.
- R7: `auxErr` is high for exactly one cycle, the cycle after a comma-position word whose mask bits [31:24] are not all zero. In every other case it is low.
- R8: `errSticky` rises together with `auxErr` and stays high until `errClr` is applied. If a new error and `errClr` come in the same cycle, the error wins.
- R9: While reset is low, the outputs hold these values: the position is all zero, `ctrlSlot` shows the word-0 pattern, and `txWord`, `auxErr` and `errSticky` are zero. The latency pipeline is cleared, so no comma is matched to words applied before the first position has aged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| framerWord | input | 32 | Framer word for the position being merged, applied in the same cycle as the data and mask |
| auxData | input | 32 | User data word |
| auxMask | input | 32 | Per-bit insertion mask, 1 selects `auxData` |
| errClr | input | 1 | Clears `errSticky` |
| seqZ | output | clog2(HF_COUNT) | Announced hyperframe number |
| seqX | output | clog2(BF_COUNT) | Announced basic-frame index |
| seqW | output | clog2(WORDS_PER_BF) | Announced word index |
| ctrlSlot | output | 4 | Control-word lanes of the announced word, bit 3 = bits [31:24] |
| txWord | output | 32 | Merged outgoing word |
| auxErr | output | 1 | One-cycle pulse when the comma byte was masked |
| errSticky | output | 1 | Sticky record of any `auxErr` |

## Verification
The position and `ctrlSlot` expected in any cycle are derived from the count of cycles since reset was released, and the bench compares them in that same cycle. Stimulus for a position shown in cycle c is driven in cycle c+1+`AUX_LATENCY`. `txWord`, `auxErr` and `errSticky` are checked against values predicted from that stimulus one cycle later. All sampling happens on the falling edge, halfway between the edge that drives the inputs and the edge that registers the result. Random masks are mixed with spans of all-zero and all-one masks, so the comma position is hit both cleanly and while masked.

// File: rtl/aux_merge_pkg.sv
package aux_merge_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  // Strobes handed from sequencing control to the merge datapath
  typedef struct packed {
    logic commaNow;  // data/mask applied this cycle belong to the comma word
  } auxStrobe_t;
endpackage

// File: rtl/aux_seq_ctrl.sv
module aux_seq_ctrl
  import aux_merge_pkg::*;
#(
  parameter int HF_COUNT     = 150,
  parameter int BF_COUNT     = 256,
  parameter int WORDS_PER_BF = 4,
  parameter int CW_BYTES     = 1,
  parameter int AUX_LATENCY  = 0
) (
  input  logic                            clk,
  input  logic                            rstN,
  output logic [$clog2(HF_COUNT)-1:0]     seqZ,
  output logic [$clog2(BF_COUNT)-1:0]     seqX,
  output logic [$clog2(WORDS_PER_BF)-1:0] seqW,
  output logic [LANES-1:0]                ctrlSlot,
  output auxStrobe_t                      strobe
);
  localparam int ZW    = $clog2(HF_COUNT);
  localparam int XW    = $clog2(BF_COUNT);
  localparam int WW    = $clog2(WORDS_PER_BF);
  localparam int DEPTH = 1 + AUX_LATENCY;
  localparam logic [ZW-1:0] Z_LAST = ZW'(HF_COUNT - 1);
  localparam logic [XW-1:0] X_LAST = XW'(BF_COUNT - 1);
  localparam logic [WW-1:0] W_LAST = WW'(WORDS_PER_BF - 1);

  logic [ZW-1:0] nextZ;
  logic [XW-1:0] nextX;
  logic [WW-1:0] nextW;
  logic [LANES-1:0] cwPattern;
  logic [DEPTH-1:0] commaPipe;
  logic isComma;

  // Lane pattern of control-word bytes, first byte sent is the top lane
  for (genvar gi = 0; gi < LANES; gi++) begin : g_cw
    assign cwPattern[LANES-1-gi] = (gi < CW_BYTES);
  end

  always_comb begin
    nextW = (seqW == W_LAST) ? '0 : seqW + 1'b1;
    nextX = seqX;
    nextZ = seqZ;
    if (seqW == W_LAST) begin
      nextX = (seqX == X_LAST) ? '0 : seqX + 1'b1;
      if (seqX == X_LAST) nextZ = (seqZ == Z_LAST) ? '0 : seqZ + 1'b1;
    end
  end

  assign isComma = (seqZ == '0) && (seqX == '0) && (seqW == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqZ     <= '0;
      seqX     <= '0;
      seqW     <= '0;
      ctrlSlot <= cwPattern;
    end else begin
      seqZ     <= nextZ;
      seqX     <= nextX;
      seqW     <= nextW;
      ctrlSlot <= (nextW == '0) ? cwPattern : '0;
    end
  end

  // Latency alignment: comma flag ages by 1 + AUX_LATENCY cycles
  if (DEPTH == 1) begin : g_pipe1
    always_ff @(posedge clk) begin
      if (!rstN) commaPipe <= '0;
      else       commaPipe <= isComma;
    end
  end else begin : g_pipeN
    always_ff @(posedge clk) begin
      if (!rstN) commaPipe <= '0;
      else       commaPipe <= {commaPipe[DEPTH-2:0], isComma};
    end
  end

  assign strobe.commaNow = commaPipe[DEPTH-1];

  // R1
  wordWrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqW == W_LAST) |=> (seqW == '0));
  // R1
  frameHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqW != W_LAST) |=> ($stable(seqX) && $stable(seqZ)));
  // R2
  ctrlWord_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlSlot != '0) |-> (seqW == '0));
endmodule

// File: rtl/aux_merge_dp.sv
module aux_merge_dp
  import aux_merge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  auxStrobe_t        strobe,
  input  logic [WORD_W-1:0] framerWord,
  input  logic [WORD_W-1:0] auxData,
  input  logic [WORD_W-1:0] auxMask,
  input  logic              errClr,
  output logic [WORD_W-1:0] txWord,
  output logic              auxErr,
  output logic              errSticky
);
  localparam int COMMA_LO = WORD_W - BYTE_W;

  logic [WORD_W-1:0] mergedWord;
  logic errNow;

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    localparam int LO = gl * BYTE_W;
    logic [BYTE_W-1:0] mixByte;
    assign mixByte = (framerWord[LO +: BYTE_W] & ~auxMask[LO +: BYTE_W])
                   | (auxData[LO +: BYTE_W] & auxMask[LO +: BYTE_W]);
    if (gl == LANES - 1) begin : g_comma
      assign mergedWord[LO +: BYTE_W] = strobe.commaNow ? framerWord[LO +: BYTE_W] : mixByte;
    end else begin : g_plain
      assign mergedWord[LO +: BYTE_W] = mixByte;
    end
  end

  assign errNow = strobe.commaNow && (auxMask[COMMA_LO +: BYTE_W] != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWord    <= '0;
      auxErr    <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      txWord    <= mergedWord;
      auxErr    <= errNow;
      errSticky <= errNow | (errSticky & ~errClr);
    end
  end

  // R6
  commaKeep_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.commaNow) |-> (txWord[COMMA_LO +: BYTE_W] == $past(framerWord[COMMA_LO +: BYTE_W])));
  // R7
  errCause_chk: assert property (@(posedge clk) disable iff (!rstN)
    auxErr |-> ($past(strobe.commaNow) && ($past(auxMask[COMMA_LO +: BYTE_W]) != '0)));
  // R8
  stickyErr_chk: assert property (@(posedge clk) disable iff (!rstN)
    auxErr |-> errSticky);
endmodule

// File: rtl/aux_frame_merge.sv
module aux_frame_merge
  import aux_merge_pkg::*;
#(
  parameter int HF_COUNT     = 150,
  parameter int BF_COUNT     = 256,
  parameter int WORDS_PER_BF = 4,
  parameter int CW_BYTES     = 1,
  parameter int AUX_LATENCY  = 0
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [31:0]                     framerWord,
  input  logic [31:0]                     auxData,
  input  logic [31:0]                     auxMask,
  input  logic                            errClr,
  output logic [$clog2(HF_COUNT)-1:0]     seqZ,
  output logic [$clog2(BF_COUNT)-1:0]     seqX,
  output logic [$clog2(WORDS_PER_BF)-1:0] seqW,
  output logic [3:0]                      ctrlSlot,
  output logic [31:0]                     txWord,
  output logic                            auxErr,
  output logic                            errSticky
);
  auxStrobe_t strobe;

  aux_seq_ctrl #(
    .HF_COUNT(HF_COUNT), .BF_COUNT(BF_COUNT), .WORDS_PER_BF(WORDS_PER_BF),
    .CW_BYTES(CW_BYTES), .AUX_LATENCY(AUX_LATENCY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .seqZ(seqZ), .seqX(seqX), .seqW(seqW),
    .ctrlSlot(ctrlSlot), .strobe(strobe)
  );

  aux_merge_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .framerWord(framerWord),
    .auxData(auxData), .auxMask(auxMask), .errClr(errClr),
    .txWord(txWord), .auxErr(auxErr), .errSticky(errSticky)
  );
endmodule

// File: tb/tb_aux_frame_merge.sv
module tb_aux_frame_merge;
  localparam int CLK_PERIOD = 10;
  localparam int HF = 3, BF = 4, WPB = 4, CWB = 2, LAT = 2;
  localparam int D = 1 + LAT;
  localparam int HYPER = HF * BF * WPB;
  localparam int RUN = 3000;

  logic clk = 1'b0, rstN = 1'b0, errClr = 1'b0;
  logic [31:0] framerWord = '0, auxData = '0, auxMask = '0;
  logic [$clog2(HF)-1:0] seqZ;
  logic [$clog2(BF)-1:0] seqX;
  logic [$clog2(WPB)-1:0] seqW;
  logic [3:0] ctrlSlot;
  logic [31:0] txWord;
  logic auxErr, errSticky;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [31:0] expTx = '0;
  logic expErr = 1'b0, expSticky = 1'b0;
  int unsigned seed = 32'd12345;

  aux_frame_merge #(.HF_COUNT(HF), .BF_COUNT(BF), .WORDS_PER_BF(WPB),
                    .CW_BYTES(CWB), .AUX_LATENCY(LAT)) dut (
    .clk(clk), .rstN(rstN), .framerWord(framerWord), .auxData(auxData),
    .auxMask(auxMask), .errClr(errClr), .seqZ(seqZ), .seqX(seqX), .seqW(seqW),
    .ctrlSlot(ctrlSlot), .txWord(txWord), .auxErr(auxErr), .errSticky(errSticky)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit isCommaAux(int c);
    return (c - D >= 0) && (((c - D) % HYPER) == 0);
  endfunction

  function automatic logic [31:0] mergeExp(logic [31:0] f, logic [31:0] d,
                                           logic [31:0] m, bit comma);
    logic [31:0] r;
    r = (f & ~m) | (d & m);
    if (comma) r[31:24] = f[31:24];
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 seqZ", 32'(seqZ), 0);
    check("R9 seqX", 32'(seqX), 0);
    check("R9 seqW", 32'(seqW), 0);
    check("R9 ctrlSlot", 32'(ctrlSlot), 32'hC);
    check("R9 txWord", txWord, 0);
    check("R9 auxErr", 32'(auxErr), 0);
    check("R9 errSticky", 32'(errSticky), 0);
    void'($urandom(seed));
    rstN = 1'b1;
    for (int c = 0; c < RUN; c++) begin
      logic [31:0] f, d, m;
      bit comma, clr, err;
      int w, x, z;
      if (c > 0) @(negedge clk);
      w = c % WPB; x = (c / WPB) % BF; z = (c / (WPB * BF)) % HF;
      // R1 counter nesting and wrap
      check("R1 seqW", 32'(seqW), 32'(w));
      check("R1 seqX", 32'(seqX), 32'(x));
      check("R1 seqZ", 32'(seqZ), 32'(z));
      // R2 control lanes (bit3 = first byte), aligned with position
      check("R2 ctrlSlot", 32'(ctrlSlot), (w == 0) ? 32'hC : 32'h0);
      // R3/R4/R5/R6 merged word from previous cycle's stimulus
      check("R3 R4 R6 txWord", txWord, expTx);
      // R7 error pulse
      check("R7 auxErr", 32'(auxErr), 32'(expErr));
      // R8 sticky
      check("R8 errSticky", 32'(errSticky), 32'(expSticky));
      // new stimulus
      comma = isCommaAux(c);
      f = $urandom; d = $urandom;
      if (c < 200)      m = '0;
      else if (c < 400) m = 32'hFFFF_FFFF;
      else begin
        m = $urandom;
        if (comma && ($urandom % 2 == 0)) m[31:24] = 8'h00;
      end
      clr = (c % 61 == 30) || (c == RUN - 200);
      if (c == RUN - 200 + D) clr = 1'b0;
      framerWord = f; auxData = d; auxMask = m; errClr = clr;
      err = comma && (m[31:24] != 8'h00);
      expTx = mergeExp(f, d, m, comma);
      expErr = err;
      expSticky = err | (expSticky & ~clr);
    end
    @(negedge clk);
    check("R3 R4 R6 txWord final", txWord, expTx);
    check("R7 auxErr final", 32'(auxErr), 32'(expErr));
    check("R8 errSticky final", 32'(errSticky), 32'(expSticky));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule